// File: doc/BRIEF.md
# Gray-Scale Frame Rate Modulator

This block turns a stream of 2-bit gray pixel codes into a single on/off drive bit per pixel, so that a two-level LCD panel can show up to four shades of gray. The shading comes from temporal dithering. Over a cycle of 16 refresh frames, each pixel is driven on in a fraction of the frames, and that fraction sets its apparent brightness.

A 12-bit palette input maps each gray code to one of seven duty levels. An 8-bit offset input holds a column step and a row step. These steps shift the dither phase of each pixel according to its position, so that neighbouring pixels do not all switch on in the same frame. A frame-start strobe advances an internal 16-frame counter. Each valid pixel is presented with its column and row, and its drive bit appears two clock cycles later.

Top module: `frm_modulator`

## Requirements
- R1: After reset, `out_valid` is 0 and the frame counter is 0, so the first pixels use frame number 0.
- R2: Gray code k selects the 3-bit density index `gray_map[3k+2:3k]`. Index 0..6 means 0, 4, 5, 8, 11, 12 and 16 on-frames out of 16, and index 7 means 16.
- R3: A pixel whose selected density is 0 frames is never driven on, whatever its phase.
- R4: A pixel whose selected density is 16 frames is always driven on, whatever its phase.
- R5: The phase is (frame + (col mod 16)·xstep + (row mod 16)·ystep) mod 16, where xstep is `phase_offs[3:0]` and ystep is `phase_offs[7:4]`. The pixel is on when the 4-bit bit-reversal of the phase is less than the on-frame count.
- R6: Each cycle in which `frame_start` is high advances the frame counter by one, modulo 16. A pixel presented in that same cycle still uses the old frame value.
- R7: Over any 16 consecutive frames, a fixed pixel with a fixed code and fixed settings is on in exactly the programmed number of frames.
- R8: `out_valid` and `out_on` for a pixel appear exactly two cycles after it is presented with `pix_valid` high. `out_valid` is 0 two cycles after `pix_valid` is low.
- R9: Every 4-bit step value, including zero and even values, is accepted, and R5 and R7 hold for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Advances the 16-frame counter |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_code | input | 2 | Gray code of the pixel |
| pix_col | input | COL_W | Column of the pixel |
| pix_row | input | ROW_W | Row of the pixel |
| gray_map | input | 12 | Gray-code-to-density palette, 3 bits per code |
| phase_offs | input | 8 | Row step [7:4] and column step [3:0] |
| out_valid | output | 1 | Drive bit valid |
| out_on | output | 1 | Pixel drive bit |

## Verification
The bench builds the block with COL_W=5 and ROW_W=3. With these widths it can sweep columns 0 to 7 and rows 0 to 3 for every gray code, through full 16-frame cycles, under three palette and step settings. Together the settings cover all eight density indices, odd steps, even steps and zero steps. Every drive bit is checked against the phase formula, and the on-frames of each pixel are counted over each 16-frame cycle. A separate case presents a pixel in the same cycle as the frame strobe.

// File: rtl/frm_pkg.sv
package frm_pkg;
    localparam int CODE_W = 2;
    localparam int IDX_W  = 3;
    localparam int FW     = 4;
    localparam int CNT_W  = FW + 1;
    localparam int NCODES = 1 << CODE_W;
    localparam int MAP_W  = NCODES * IDX_W;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(1 << FW);

    function automatic logic [CNT_W-1:0] idx_to_frames(input logic [IDX_W-1:0] idx);
        logic [CNT_W-1:0] f;
        unique case (idx)
            3'd0: f = 5'd0;
            3'd1: f = 5'd4;
            3'd2: f = 5'd5;
            3'd3: f = 5'd8;
            3'd4: f = 5'd11;
            3'd5: f = 5'd12;
            default: f = 5'd16;
        endcase
        return f;
    endfunction

    function automatic logic [FW-1:0] bit_rev(input logic [FW-1:0] p);
        logic [FW-1:0] r;
        for (int i = 0; i < FW; i++) r[i] = p[FW-1-i];
        return r;
    endfunction
endpackage

// File: rtl/frm_frame_ctr.sv
module frm_frame_ctr
    import frm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    output logic [FW-1:0] frame_no
);
    always_ff @(posedge clk) begin
        if (!rst_n)           frame_no <= '0;
        else if (frame_start) frame_no <= frame_no + FW'(1);
    end

    // R6
    frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> frame_no == FW'($past(frame_no) + FW'(1)));
    // R6
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(frame_no));
endmodule

// File: rtl/frm_palette.sv
module frm_palette
    import frm_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [MAP_W-1:0]  gray_map,
    output logic [CNT_W-1:0]  on_frames
);
    logic [IDX_W-1:0] fields [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_field
        assign fields[g] = gray_map[g*IDX_W +: IDX_W];
    end

    always_comb on_frames = idx_to_frames(fields[code]);
endmodule

// File: rtl/frm_phase.sv
module frm_phase
    import frm_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int ROW_W = 9
) (
    input  logic [FW-1:0]    frame_no,
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    input  logic [2*FW-1:0]  phase_offs,
    output logic [FW-1:0]    phase
);
    logic [FW-1:0] xstep, ystep, col_lo, row_lo;

    always_comb begin
        xstep  = phase_offs[FW-1:0];
        ystep  = phase_offs[2*FW-1:FW];
        col_lo = FW'(col);
        row_lo = FW'(row);
        phase  = frame_no + col_lo * xstep + row_lo * ystep;
    end
endmodule

// File: rtl/frm_modulator.sv
module frm_modulator
    import frm_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             pix_valid,
    input  logic [1:0]       pix_code,
    input  logic [COL_W-1:0] pix_col,
    input  logic [ROW_W-1:0] pix_row,
    input  logic [11:0]      gray_map,
    input  logic [7:0]       phase_offs,
    output logic             out_valid,
    output logic             out_on
);
    logic [FW-1:0]    frame_no;
    logic [CNT_W-1:0] sel_frames;
    logic [FW-1:0]    pix_phase;

    logic             s1_valid;
    logic [CNT_W-1:0] s1_frames;
    logic [FW-1:0]    s1_phase;

    frm_frame_ctr i_ctr (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_no(frame_no)
    );

    frm_palette i_pal (
        .code(pix_code), .gray_map(gray_map), .on_frames(sel_frames)
    );

    frm_phase #(.COL_W(COL_W), .ROW_W(ROW_W)) i_phase (
        .frame_no(frame_no), .col(pix_col), .row(pix_row),
        .phase_offs(phase_offs), .phase(pix_phase)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_frames <= '0;
            s1_phase  <= '0;
        end else begin
            s1_valid  <= pix_valid;
            s1_frames <= sel_frames;
            s1_phase  <= pix_phase;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_on    <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            out_on    <= s1_valid &&
                         ((s1_frames == FULL) || ({1'b0, bit_rev(s1_phase)} < s1_frames));
        end
    end

    // R8
    lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pix_valid, 2) |-> out_valid);
    // R8
    lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pix_valid, 2) |-> !out_valid && !out_on);
    // R3
    dens_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pix_valid, 2) && $past(sel_frames, 2) == '0) |-> !out_on);
    // R4
    dens_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pix_valid, 2) && $past(sel_frames, 2) == FULL) |-> out_on);
endmodule

// File: tb/test_frm_modulator.sv
`timescale 1ns/1ps
module test_frm_modulator;
    localparam int COL_W = 5;
    localparam int ROW_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic pix_valid = 1'b0;
    logic [1:0] pix_code = '0;
    logic [COL_W-1:0] pix_col = '0;
    logic [ROW_W-1:0] pix_row = '0;
    logic [11:0] gray_map = '0;
    logic [7:0] phase_offs = '0;
    logic out_valid, out_on;

    int checks = 0;
    int errors = 0;
    int exp_frame = 0;
    int on_cnt [4][8][4];

    always #2 clk = ~clk;

    frm_modulator #(.COL_W(COL_W), .ROW_W(ROW_W)) i_frm_modulator (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
        .pix_code(pix_code), .pix_col(pix_col), .pix_row(pix_row),
        .gray_map(gray_map), .phase_offs(phase_offs),
        .out_valid(out_valid), .out_on(out_on)
    );

    function automatic int dens(int idx);
        case (idx)
            0: return 0;
            1: return 4;
            2: return 5;
            3: return 8;
            4: return 11;
            5: return 12;
            default: return 16;
        endcase
    endfunction

    function automatic int code_frames(int code);
        return dens((gray_map >> (3 * code)) & 7);
    endfunction

    function automatic int brev(int p);
        return ((p & 1) << 3) | ((p & 2) << 1) | ((p & 4) >> 1) | ((p & 8) >> 3);
    endfunction

    function automatic int exp_on(int code, int c, int r, int f);
        int ph;
        int n;
        ph = (f + (c % 16) * (phase_offs & 15) + (r % 16) * (phase_offs >> 4)) % 16;
        n = code_frames(code);
        if (n == 16) return 1;
        return (brev(ph) < n) ? 1 : 0;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic send(int code, int c, int r, bit fs, string req);
        int e;
        e = exp_on(code, c, r, exp_frame);
        @(negedge clk);
        pix_valid = 1'b1; pix_code = 2'(code); pix_col = COL_W'(c); pix_row = ROW_W'(r);
        frame_start = fs;
        @(negedge clk);
        pix_valid = 1'b0; frame_start = 1'b0;
        if (fs) exp_frame = (exp_frame + 1) % 16;
        @(negedge clk);
        chk(out_valid == 1'b1, "R8", int'(out_valid), 1);
        chk(int'(out_on) == e, req, int'(out_on), e);
        if (out_on) on_cnt[code][c][r]++;
    endtask

    task automatic next_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        exp_frame = (exp_frame + 1) % 16;
        chk(out_valid == 1'b0, "R8", int'(out_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] maps [3];
        logic [7:0]  offs [3];
        maps[0] = {3'd3, 3'd2, 3'd1, 3'd0};
        maps[1] = {3'd7, 3'd6, 3'd5, 3'd4};
        maps[2] = {3'd5, 3'd0, 3'd3, 3'd6};
        offs[0] = 8'h53;
        offs[1] = 8'h72;
        offs[2] = 8'h00;

        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        chk(out_on == 1'b0, "R1", int'(out_on), 0);
        rst_n = 1'b1;

        for (int cfg = 0; cfg < 3; cfg++) begin
            gray_map = maps[cfg];
            phase_offs = offs[cfg];
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 8; b++)
                    for (int d = 0; d < 4; d++) on_cnt[a][b][d] = 0;
            for (int fr = 0; fr < 16; fr++) begin
                for (int code = 0; code < 4; code++)
                    for (int c = 0; c < 8; c++)
                        for (int r = 0; r < 4; r++) begin
                            string tag;
                            if (cfg == 0 && fr == 0) tag = "R1 R2 R5";
                            else if (code_frames(code) == 0) tag = "R2 R3";
                            else if (code_frames(code) == 16) tag = "R2 R4";
                            else if (cfg == 0) tag = "R2 R5 R6";
                            else tag = "R2 R5 R9";
                            send(code, c, r, 1'b0, tag);
                        end
                next_frame();
            end
            for (int code = 0; code < 4; code++)
                for (int c = 0; c < 8; c++)
                    for (int r = 0; r < 4; r++)
                        chk(on_cnt[code][c][r] == code_frames(code), "R7 R9",
                            on_cnt[code][c][r], code_frames(code));
        end

        gray_map = {3'd2, 3'd2, 3'd2, 3'd2};
        phase_offs = 8'h31;
        for (int k = 0; k < 20; k++) begin
            send(k % 4, k % 8, k % 4, 1'b1, "R6");
            send(k % 4, k % 8, k % 4, 1'b0, "R6");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule